// File: doc/BRIEF.md
# Reconfiguration Word-Stream Write Sequencer

This block sits on the user side of a transceiver dynamic-reconfiguration controller and streams a fixed, precomputed sequence of 16-bit configuration words into it. The controller accepts only writes. Each word travels with a single-cycle write strobe, and the strobe is issued only while the controller's busy flag is low. Before the first word, the sequencer captures the reconfiguration mode, the direction select and the logical channel address. It holds them unchanged on its outputs until the run ends.

After the last word has been accepted, the controller re-tunes the transmit PLL. The sequencer waits for the PLL lock indication to drop and then come back. Only then does it pulse completion. If lock does not return within a set number of cycles, it pulses a lock error instead and goes back to idle. A request with an illegal mode or direction issues no writes and is flagged. The word sequence comes from an internal ROM. The ROM is either computed as logic or built as a table, selected by a parameter.

Top module: `rcfg_word_sequencer`

## Requirements
- R1: A start request is accepted only in idle, with mode_i equal to 3'b001 (channel reconfiguration with transmit-PLL select) and a legal direction. From the first write to the end of the run, ctl_mode_o reads 3'b001, and ctl_dir_o and ctl_addr_o hold the values captured at acceptance.
- R2: Direction encoding is 2'b01 receive, 2'b10 transmit, 2'b11 both. A start with dir_i = 2'b00 or any mode other than 3'b001 issues no write, and err_cfg_o is high for exactly the one cycle after the request.
- R3: ctl_write_o is high only in a cycle where busy_i is low, and never in two consecutive cycles. While busy_i stays high, no write is issued.
- R4: Each run issues exactly DEPTH writes. Write k (k counting from 0) carries ctl_data_o = ((SEED + k*STRIDE) XOR (k << 8)) mod 2^16.
- R5: After a strobe, the next strobe (or the move to the lock wait) happens only after busy_i has been seen high and then low again.
- R6: A start request that arrives while a run is in progress has no effect. The captured direction and address are kept, and the word count is not restarted.
- R7: After the last word, done_o pulses for one cycle once pll_locked_i is sampled high after having been low at some point since the run was accepted. A lock that never dropped does not count.
- R8: If the relock of R7 is not seen within LOCK_TIMEOUT cycles of entering the lock wait, err_lock_o pulses for one cycle, done_o stays low and the block returns to idle.
- R9: After reset, ctl_write_o, done_o, err_cfg_o and err_lock_o are low, and ctl_mode_o, ctl_dir_o and ctl_addr_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reconfiguration clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to stream the word sequence |
| mode_i | input | 3 | Requested reconfiguration mode |
| dir_i | input | 2 | Requested direction: receive, transmit or both |
| chan_addr_i | input | ADDR_W | Logical channel to reconfigure |
| busy_i | input | 1 | Controller busy flag |
| pll_locked_i | input | 1 | Transmit PLL lock indication |
| ctl_mode_o | output | 3 | Mode select driven to the controller |
| ctl_dir_o | output | 2 | Direction select driven to the controller |
| ctl_addr_o | output | ADDR_W | Channel address driven to the controller |
| ctl_data_o | output | 16 | Configuration word for the current write |
| ctl_write_o | output | 1 | Single-cycle write strobe |
| done_o | output | 1 | One-cycle completion pulse after relock |
| err_cfg_o | output | 1 | One-cycle pulse on a rejected request |
| err_lock_o | output | 1 | One-cycle pulse on relock timeout |

## Verification
The in-RTL properties assume that the controller answers every strobe by raising busy within a few cycles and lowering it later. They also assume busy never drops during the same cycle it is sampled to close a word. The bench's controller model keeps to this. It raises busy one or two cycles after each strobe and holds it for one to three cycles. The model also drops lock at the first write and restores it only after the final busy fall. To show that the block waits, busy is separately forced high across the start of one run. Some runs break the lock assumption on purpose, leaving lock low or never letting it drop, to reach the timeout path.

// File: rtl/rcfg_pkg.sv
package rcfg_pkg;

   localparam int DATA_W = 16;

   localparam logic [2:0] MODE_CHAN_TXPLL = 3'b001;

   localparam logic [1:0] DIR_NONE = 2'b00;
   localparam logic [1:0] DIR_RX   = 2'b01;
   localparam logic [1:0] DIR_TX   = 2'b10;
   localparam logic [1:0] DIR_BOTH = 2'b11;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_RUN  = 2'd1,
      SQ_LOCK = 2'd2
   } sq_state_t;

   typedef enum logic [1:0] {
      HS_READY = 2'd0,
      HS_RISE  = 2'd1,
      HS_FALL  = 2'd2
   } hs_phase_t;

endpackage

// File: rtl/rcfg_word_rom.sv
module rcfg_word_rom #(
   parameter int          DEPTH     = 16,
   parameter int          IDX_W     = 4,
   parameter logic [15:0] SEED      = 16'h1A2B,
   parameter logic [15:0] STRIDE    = 16'h0137,
   parameter int          ROM_STYLE = 0
) (
   input  logic [IDX_W-1:0]          idx_i,
   output logic [rcfg_pkg::DATA_W-1:0] word_o
);
   import rcfg_pkg::*;

   initial begin
      assert (ROM_STYLE == 0 || ROM_STYLE == 1)
         else $error("rcfg_word_rom: ROM_STYLE must be 0 or 1");
      assert (DEPTH <= (1 << IDX_W))
         else $error("rcfg_word_rom: IDX_W too narrow for DEPTH");
   end

   function automatic logic [DATA_W-1:0] word_at(input int unsigned k);
      logic [31:0] acc;
      acc = 32'(SEED) + (32'(k) * 32'(STRIDE));
      acc = acc ^ (32'(k) << 8);
      return acc[DATA_W-1:0];
   endfunction

   generate
      if (ROM_STYLE == 0) begin : g_calc
         always_comb word_o = word_at(32'(idx_i));
      end else begin : g_table
         logic [DATA_W-1:0] tbl [DEPTH];
         for (genvar g = 0; g < DEPTH; g++) begin : g_ent
            assign tbl[g] = word_at(g);
         end
         always_comb begin
            if (int'(idx_i) < DEPTH) word_o = tbl[idx_i];
            else                     word_o = '0;
         end
      end
   endgenerate

endmodule

// File: rtl/rcfg_wr_handshake.sv
module rcfg_wr_handshake (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   input  logic busy_i,
   output logic strobe_o,
   output logic word_done_o
);
   import rcfg_pkg::*;

   hs_phase_t phase_q;

   assign strobe_o    = req_i && (phase_q == HS_READY) && !busy_i;
   assign word_done_o = (phase_q == HS_FALL) && !busy_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= HS_READY;
      end else begin
         case (phase_q)
            HS_READY: if (strobe_o) phase_q <= HS_RISE;
            HS_RISE:  if (busy_i)   phase_q <= HS_FALL;
            HS_FALL:  if (!busy_i)  phase_q <= HS_READY;
            default:                phase_q <= HS_READY;
         endcase
      end
   end

   AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_o |=> !strobe_o); // R3

   AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      word_done_o |-> $past(busy_i)); // R5

   AST_STROBE_WAITS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_o && $past(phase_q) != HS_READY) |-> $past(word_done_o)); // R5

endmodule

// File: rtl/rcfg_lock_watch.sv
module rcfg_lock_watch #(
   parameter int LOCK_TIMEOUT = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic arm_i,
   input  logic pll_locked_i,
   output logic relock_o,
   output logic timeout_o
);
   localparam int CNT_W = $clog2(LOCK_TIMEOUT + 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOCK_TIMEOUT - 1);

   initial begin
      assert (LOCK_TIMEOUT >= 2)
         else $error("rcfg_lock_watch: LOCK_TIMEOUT must be at least 2");
   end

   logic             dropped_q;
   logic [CNT_W-1:0] cnt_q;

   assign relock_o  = arm_i && dropped_q && pll_locked_i;
   assign timeout_o = arm_i && !relock_o && (cnt_q == CNT_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dropped_q <= 1'b0;
      end else if (clear_i) begin
         dropped_q <= 1'b0;
      end else if (!pll_locked_i) begin
         dropped_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!arm_i) begin
         cnt_q <= '0;
      end else if (cnt_q != CNT_LAST) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   AST_RELOCK_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
      relock_o |=> !arm_i); // R7

   AST_TIMEOUT_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_o |=> !arm_i); // R8

endmodule

// File: rtl/rcfg_word_sequencer.sv
module rcfg_word_sequencer #(
   parameter int          DEPTH        = 16,
   parameter int          ADDR_W       = 9,
   parameter int          LOCK_TIMEOUT = 4096,
   parameter logic [15:0] SEED         = 16'h1A2B,
   parameter logic [15:0] STRIDE       = 16'h0137,
   parameter int          ROM_STYLE    = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [2:0]        mode_i,
   input  logic [1:0]        dir_i,
   input  logic [ADDR_W-1:0] chan_addr_i,
   input  logic              busy_i,
   input  logic              pll_locked_i,
   output logic [2:0]        ctl_mode_o,
   output logic [1:0]        ctl_dir_o,
   output logic [ADDR_W-1:0] ctl_addr_o,
   output logic [15:0]       ctl_data_o,
   output logic              ctl_write_o,
   output logic              done_o,
   output logic              err_cfg_o,
   output logic              err_lock_o
);
   import rcfg_pkg::*;

   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

   initial begin
      assert (DEPTH >= 1 && DEPTH <= 4096)
         else $error("rcfg_word_sequencer: DEPTH out of range");
      assert (ADDR_W >= 1)
         else $error("rcfg_word_sequencer: ADDR_W must be positive");
   end

   sq_state_t         state_q;
   logic [IDX_W-1:0]  idx_q;
   logic [2:0]        mode_q;
   logic [1:0]        dir_q;
   logic [ADDR_W-1:0] addr_q;
   logic              done_q, err_cfg_q, err_lock_q;

   logic cfg_ok, accept, hs_req, hs_strobe, hs_word_done;
   logic lk_relock, lk_timeout, last_word;

   assign cfg_ok    = (mode_i == MODE_CHAN_TXPLL) && (dir_i != DIR_NONE);
   assign accept    = (state_q == SQ_IDLE) && start_i && cfg_ok;
   assign hs_req    = (state_q == SQ_RUN);
   assign last_word = (idx_q == LAST_IDX);

   rcfg_word_rom #(
      .DEPTH     (DEPTH),
      .IDX_W     (IDX_W),
      .SEED      (SEED),
      .STRIDE    (STRIDE),
      .ROM_STYLE (ROM_STYLE)
   ) u_rom (
      .idx_i  (idx_q),
      .word_o (ctl_data_o)
   );

   rcfg_wr_handshake u_hs (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_i       (hs_req),
      .busy_i      (busy_i),
      .strobe_o    (hs_strobe),
      .word_done_o (hs_word_done)
   );

   rcfg_lock_watch #(
      .LOCK_TIMEOUT (LOCK_TIMEOUT)
   ) u_lock (
      .clk          (clk),
      .rst_n        (rst_n),
      .clear_i      (accept),
      .arm_i        (state_q == SQ_LOCK),
      .pll_locked_i (pll_locked_i),
      .relock_o     (lk_relock),
      .timeout_o    (lk_timeout)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= SQ_IDLE;
         idx_q      <= '0;
         mode_q     <= '0;
         dir_q      <= '0;
         addr_q     <= '0;
         done_q     <= 1'b0;
         err_cfg_q  <= 1'b0;
         err_lock_q <= 1'b0;
      end else begin
         done_q     <= 1'b0;
         err_lock_q <= 1'b0;
         err_cfg_q  <= (state_q == SQ_IDLE) && start_i && !cfg_ok;
         case (state_q)
            SQ_IDLE: begin
               if (accept) begin
                  mode_q  <= mode_i;
                  dir_q   <= dir_i;
                  addr_q  <= chan_addr_i;
                  idx_q   <= '0;
                  state_q <= SQ_RUN;
               end
            end
            SQ_RUN: begin
               if (hs_word_done) begin
                  if (last_word) state_q <= SQ_LOCK;
                  else           idx_q   <= idx_q + IDX_W'(1);
               end
            end
            SQ_LOCK: begin
               if (lk_relock) begin
                  done_q  <= 1'b1;
                  state_q <= SQ_IDLE;
               end else if (lk_timeout) begin
                  err_lock_q <= 1'b1;
                  state_q    <= SQ_IDLE;
               end
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   assign ctl_mode_o  = mode_q;
   assign ctl_dir_o   = dir_q;
   assign ctl_addr_o  = addr_q;
   assign ctl_write_o = hs_strobe;
   assign done_o      = done_q;
   assign err_cfg_o   = err_cfg_q;
   assign err_lock_o  = err_lock_q;

   AST_RUN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_write_o |-> ctl_mode_o == MODE_CHAN_TXPLL); // R1

   AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != SQ_IDLE && $past(state_q) != SQ_IDLE)
         |-> ($stable(ctl_addr_o) && $stable(ctl_dir_o))); // R6

   AST_DIR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_write_o |-> ctl_dir_o != DIR_NONE); // R2

   AST_CFG_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      err_cfg_o |-> (state_q == SQ_IDLE && !ctl_write_o)); // R2

   AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      int'(idx_q) < DEPTH); // R4

   AST_ADVANCE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SQ_RUN && $past(state_q) == SQ_RUN && idx_q != $past(idx_q))
         |-> $past(!busy_i)); // R5

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R7

   AST_OUTCOME_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && err_lock_o)); // R8

endmodule

// File: tb/sim_rcfg_word_sequencer.sv
module sim_rcfg_word_sequencer;
   localparam int CLK_PERIOD   = 10;
   localparam int DEPTH        = 5;
   localparam int ADDR_W       = 4;
   localparam int LOCK_TIMEOUT = 32;
   localparam logic [15:0] SEED   = 16'h1A2B;
   localparam logic [15:0] STRIDE = 16'h0137;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic [2:0] mode_i = 3'b001;
   logic [1:0] dir_i = 2'b11;
   logic [ADDR_W-1:0] addr_i = '0;
   logic ext_busy = 1'b0;
   logic model_busy = 1'b0;
   logic pll_locked = 1'b1;
   logic busy_i;
   assign busy_i = model_busy | ext_busy;

   logic [2:0]        ctl_mode_o;
   logic [1:0]        ctl_dir_o;
   logic [ADDR_W-1:0] ctl_addr_o;
   logic [15:0]       ctl_data_o;
   logic ctl_write_o, done_o, err_cfg_o, err_lock_o;

   rcfg_word_sequencer #(
      .DEPTH(DEPTH), .ADDR_W(ADDR_W), .LOCK_TIMEOUT(LOCK_TIMEOUT),
      .SEED(SEED), .STRIDE(STRIDE), .ROM_STYLE(1)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
      .dir_i(dir_i), .chan_addr_i(addr_i), .busy_i(busy_i),
      .pll_locked_i(pll_locked), .ctl_mode_o(ctl_mode_o), .ctl_dir_o(ctl_dir_o),
      .ctl_addr_o(ctl_addr_o), .ctl_data_o(ctl_data_o), .ctl_write_o(ctl_write_o),
      .done_o(done_o), .err_cfg_o(err_cfg_o), .err_lock_o(err_lock_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // model settings, written only by the stimulus process
   int  hold = 1, rise_dly = 0, lock_delay = 0;
   bit  drop_en = 1'b1, restore_en = 1'b1;
   logic [1:0]        exp_dir = 2'b11;
   logic [ADDR_W-1:0] exp_addr = '0;

   // monitor-owned state
   int  mon_chk = 0, mon_bad = 0;
   int  seq_idx = 0, tot_wr = 0, tot_done = 0, tot_elock = 0, tot_ecfg = 0;
   int  bphase = 0, rise_wait = 0, hi_left = 0, lk = 0;
   bit  prev_wr = 1'b0, prev_done = 1'b0;

   // stimulus-owned counters
   int n_chk = 0, n_bad = 0;

   function automatic logic [15:0] exp_word(input int k);
      logic [31:0] v;
      v = (32'(SEED) + 32'(k) * 32'(STRIDE)) ^ (32'(k) << 8);
      return v[15:0];
   endfunction

   task automatic mcheck(input bit ok, input string req, input string what,
                         input int act, input int exp);
      mon_chk++;
      if (!ok) begin
         mon_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // controller and PLL model plus scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (ctl_write_o) begin
            mcheck(busy_i == 1'b0, "R3", "strobe with busy high", int'(busy_i), 0);
            mcheck(!prev_wr, "R3", "back-to-back strobe", 1, 0);
            mcheck(bphase == 0, "R5", "strobe before busy cycle closed", bphase, 0);
            mcheck(seq_idx < DEPTH, "R4", "writes in run", seq_idx + 1, DEPTH);
            mcheck(ctl_data_o == exp_word(seq_idx), "R4", "data word",
                   int'(ctl_data_o), int'(exp_word(seq_idx)));
            mcheck(ctl_mode_o == 3'b001, "R1", "mode at write", int'(ctl_mode_o), 1);
            mcheck(ctl_dir_o == exp_dir, "R1", "direction at write",
                   int'(ctl_dir_o), int'(exp_dir));
            mcheck(ctl_addr_o == exp_addr, "R6", "address at write",
                   int'(ctl_addr_o), int'(exp_addr));
            seq_idx++;
            tot_wr++;
            if (drop_en) pll_locked = 1'b0;
            rise_wait = rise_dly;
            hi_left = hold;
            bphase = 1;
         end else if (bphase == 1) begin
            if (rise_wait == 0) begin
               model_busy = 1'b1;
               bphase = 2;
            end else rise_wait--;
         end else if (bphase == 2) begin
            if (hi_left <= 1) begin
               model_busy = 1'b0;
               bphase = 0;
            end else hi_left--;
         end
         if (seq_idx == DEPTH && bphase == 0 && restore_en && !pll_locked) begin
            if (lk >= lock_delay) pll_locked = 1'b1;
            else lk++;
         end
         if (done_o) begin
            mcheck(!prev_done, "R7", "done wider than one cycle", 2, 1);
            tot_done++;
         end
         if (err_lock_o) tot_elock++;
         if (err_cfg_o) tot_ecfg++;
         if (done_o || err_lock_o) begin
            seq_idx = 0;
            lk = 0;
            pll_locked = 1'b1;
         end
         prev_wr = ctl_write_o;
         prev_done = done_o;
      end
   end

   task automatic run(input logic [1:0] d, input logic [ADDR_W-1:0] a,
                      input int h, input int dz, input int ld,
                      input bit drop, input bit restore, input bit mid_start,
                      input int busy_pre, input bit expect_done);
      int b_wr, b_done, b_elock, b_ecfg;
      @(negedge clk);
      hold = h; rise_dly = dz; lock_delay = ld;
      drop_en = drop; restore_en = restore;
      exp_dir = d; exp_addr = a;
      b_wr = tot_wr; b_done = tot_done; b_elock = tot_elock; b_ecfg = tot_ecfg;
      mode_i = 3'b001; dir_i = d; addr_i = a; start_i = 1'b1;
      if (busy_pre > 0) ext_busy = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      if (busy_pre > 0) begin
         repeat (busy_pre) @(negedge clk);
         check(tot_wr == b_wr, "R3", "writes while busy held", tot_wr - b_wr, 0);
         ext_busy = 1'b0;
      end
      if (mid_start) begin
         for (int c = 0; c < 200 && tot_wr - b_wr < 2; c++) @(negedge clk);
         dir_i = ~d; addr_i = ~a; start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
         @(negedge clk);
         check(ctl_addr_o == a, "R6", "address after mid-run start",
               int'(ctl_addr_o), int'(a));
         check(ctl_dir_o == d, "R6", "direction after mid-run start",
               int'(ctl_dir_o), int'(d));
      end
      for (int c = 0; c < 600 && tot_done == b_done && tot_elock == b_elock; c++)
         @(negedge clk);
      repeat (4) @(negedge clk);
      check(tot_wr - b_wr == DEPTH, "R4", "writes per run", tot_wr - b_wr, DEPTH);
      check(tot_done - b_done == (expect_done ? 1 : 0), "R7", "done pulses",
            tot_done - b_done, expect_done ? 1 : 0);
      check(tot_elock - b_elock == (expect_done ? 0 : 1), "R8", "lock error pulses",
            tot_elock - b_elock, expect_done ? 0 : 1);
      check(tot_ecfg == b_ecfg, "R2", "config error on legal request",
            tot_ecfg - b_ecfg, 0);
   endtask

   task automatic bad_start(input logic [2:0] m, input logic [1:0] d);
      int b_wr;
      @(negedge clk);
      b_wr = tot_wr;
      mode_i = m; dir_i = d; addr_i = 4'h5; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      check(err_cfg_o == 1'b1, "R2", "err_cfg after bad request", int'(err_cfg_o), 1);
      @(negedge clk);
      check(err_cfg_o == 1'b0, "R2", "err_cfg pulse width", int'(err_cfg_o), 0);
      repeat (8) @(negedge clk);
      check(tot_wr == b_wr, "R2", "writes after bad request", tot_wr - b_wr, 0);
      check(ctl_write_o == 1'b0 && done_o == 1'b0, "R2", "quiet after bad request",
            int'(ctl_write_o) + int'(done_o), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      $display("FAIL R7 watchdog: actual hung expected finished run");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***",
               n_chk + mon_chk + 1, n_bad + mon_bad + 1);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(ctl_write_o == 1'b0, "R9", "reset write", int'(ctl_write_o), 0);
      check(done_o == 1'b0 && err_lock_o == 1'b0 && err_cfg_o == 1'b0, "R9",
            "reset pulses", int'(done_o) + int'(err_lock_o) + int'(err_cfg_o), 0);
      check(ctl_mode_o == 3'b000 && ctl_dir_o == 2'b00 && ctl_addr_o == '0, "R9",
            "reset config", int'(ctl_mode_o) + int'(ctl_dir_o) + int'(ctl_addr_o), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 R4 R5 R7 sweep over direction, busy hold and busy rise delay
      for (int d = 1; d < 4; d++)
         for (int h = 1; h < 4; h++)
            for (int z = 0; z < 2; z++)
               run(2'(d), 4'(d * 5 + h + z), h, z, (h * 2 + z) % 7,
                   1'b1, 1'b1, 1'b0, 0, 1'b1);

      // R2 every illegal mode, then the illegal direction
      for (int m = 0; m < 8; m++)
         if (m != 1) bad_start(3'(m), 2'b11);
      bad_start(3'b001, 2'b00);

      // R6 start during a run
      run(2'b10, 4'hA, 2, 1, 3, 1'b1, 1'b1, 1'b1, 0, 1'b1);

      // R3 busy held high across the start
      run(2'b01, 4'h3, 1, 0, 2, 1'b1, 1'b1, 1'b0, 6, 1'b1);

      // R8 lock never returns
      run(2'b11, 4'h7, 1, 0, 0, 1'b1, 1'b0, 1'b0, 0, 1'b0);

      // R7 lock never dropped counts as no relock, ends in timeout
      run(2'b11, 4'h9, 2, 0, 0, 1'b0, 1'b1, 1'b0, 0, 1'b0);

      // recovery after a timeout
      run(2'b01, 4'hF, 3, 1, 5, 1'b1, 1'b1, 1'b0, 0, 1'b1);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***",
               n_chk + mon_chk, n_bad + mon_bad);
      $finish;
   end

endmodule